// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts one interrupt delivery request at a time and turns its destination field into a set of target CPUs. The set is built from the live per-CPU configuration inputs: presence bits, 8-bit physical IDs, 8-bit flat logical IDs and priority values. The block then sends the interrupt to that set according to the request's delivery mode.

Fixed and NMI deliveries go out one CPU per clock, in ascending CPU index order. Lowest-priority delivery picks a single CPU. Each request ends with a one-cycle `done` strobe, and `accepted` reports whether anything was delivered.

The upstream redirection logic raises `req_valid` for one cycle while `busy` is low. The configuration inputs must stay stable from that cycle until `done`.

Top module: `intr_route_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `accepted`, `inj_pulse` and `nmi_pulse` are all low.
- R2: With physical addressing (`req_logical`=0) and a destination of all ones, every CPU whose presence bit is set is a target.
- R3: With physical addressing and any other destination, the only target is the present CPU with the lowest index whose physical ID equals the destination. Absent CPUs never match.
- R4: With logical addressing (`req_logical`=1), a destination of zero gives no targets. Any other destination targets every present CPU whose logical ID shares at least one set bit with it.
- R5: When the resolved target set is empty, no pulse of either kind is produced, and `done` rises with `accepted` low.
- R6: Fixed mode (`req_dmode`=3'b000) raises one `inj_pulse` bit per cycle, for each target in ascending index order, with no gap between pulses. `inj_vector` and `inj_level` carry the request's vector and trigger mode while each pulse is high. `done` rises, with `accepted` high, in the cycle after the last pulse.
- R7: Lowest-priority mode (`req_dmode`=3'b001) raises exactly one `inj_pulse`. It goes to the target with the smallest priority value, and a tie goes to the lower index.
- R8: In fixed and lowest-priority modes, a request from pin 0 whose target set is non-empty is delivered to CPU 0 only.
- R9: NMI mode (`req_dmode`=3'b100) raises one `nmi_pulse` bit per cycle, for each target in ascending order, and never raises `inj_pulse`. Pin 0 gets no special treatment in this mode.
- R10: Any other `req_dmode` code delivers nothing and finishes with `accepted` low.
- R11: `busy` is high from the cycle after a request is taken until `done`. A `req_valid` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_dest | input | 8 | Destination ID or logical mask |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_dmode | input | 3 | Delivery mode code |
| req_vector | input | 8 | Interrupt vector |
| req_level | input | 1 | Trigger mode (1 = level) |
| req_pin | input | PIN_W | Source pin index |
| cpu_present | input | NCPU | Per-CPU presence |
| cpu_phys_id | input | NCPU*8 | Per-CPU physical IDs, CPU i at bits [8i+7:8i] |
| cpu_log_id | input | NCPU*8 | Per-CPU flat logical IDs |
| cpu_prio | input | NCPU*PRIW | Per-CPU priority values, lower wins |
| busy | output | 1 | Request in progress |
| inj_pulse | output | NCPU | One-cycle interrupt injection per CPU |
| inj_vector | output | 8 | Vector accompanying `inj_pulse` |
| inj_level | output | 1 | Trigger mode accompanying `inj_pulse` |
| nmi_pulse | output | NCPU | One-cycle NMI per CPU |
| done | output | 1 | One-cycle end-of-request strobe |
| accepted | output | 1 | With `done`: something was delivered |

## Verification
The bench builds the block with NCPU=8, PRIW=4 and PIN_W=5. Eight CPUs give the full 8-bit logical mask and an all-ones broadcast that covers every index. Two of those CPUs are absent, and they carry the lowest priorities and a matching physical ID, so each kind of presence gating becomes observable. Duplicate physical IDs, shared logical bits and equal priorities make the first-match and tie-break rules visible at the pulse outputs.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] DM_FIXED  = 3'b000;
  localparam logic [MODE_W-1:0] DM_LOWEST = 3'b001;
  localparam logic [MODE_W-1:0] DM_NMI    = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESOLVE,
    ST_ISSUE,
    ST_FINISH
  } route_state_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              logical;
    logic [MODE_W-1:0] dmode;
    logic [VEC_W-1:0]  vector;
    logic              level;
  } route_req_t;
endpackage

// File: rtl/lsb_isolate.sv
module lsb_isolate #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_onehot
);
  // Keeps only the lowest set bit.
  assign out_onehot = in_vec & (~in_vec + W'(1));
endmodule

// File: rtl/intr_dest_match.sv
module intr_dest_match
  import intr_route_pkg::*;
#(
  parameter int NCPU = 8
) (
  input  logic [DEST_W-1:0]      dest,
  input  logic                   logical,
  input  logic [NCPU-1:0]        present,
  input  logic [NCPU*DEST_W-1:0] phys_ids,
  input  logic [NCPU*DEST_W-1:0] log_ids,
  output logic [NCPU-1:0]        target_mask
);
  logic [NCPU-1:0] phys_hit;
  logic [NCPU-1:0] log_hit;
  logic [NCPU-1:0] phys_first;

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    assign phys_hit[g] = present[g] && (phys_ids[g*DEST_W +: DEST_W] == dest);
    assign log_hit[g]  = present[g] && (|(log_ids[g*DEST_W +: DEST_W] & dest));
  end

  lsb_isolate #(.W(NCPU)) u_first (
    .in_vec     (phys_hit),
    .out_onehot (phys_first)
  );

  always_comb begin
    if (logical) begin
      target_mask = (dest == '0) ? '0 : log_hit;
    end else if (dest == '1) begin
      target_mask = present;
    end else begin
      target_mask = phys_first;
    end
  end
endmodule

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
  parameter int NCPU = 8,
  parameter int PRIW = 8
) (
  input  logic [NCPU-1:0]      cand,
  input  logic [NCPU*PRIW-1:0] prio,
  output logic [NCPU-1:0]      pick
);
  localparam int IDXW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic            found;
  logic [PRIW-1:0] best_p;
  logic [IDXW-1:0] best_i;

  always_comb begin
    found  = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NCPU; i++) begin
      // Strict compare keeps the lower index on a tie.
      if (cand[i] && (!found || (prio[i*PRIW +: PRIW] < best_p))) begin
        found  = 1'b1;
        best_p = prio[i*PRIW +: PRIW];
        best_i = IDXW'(i);
      end
    end
    pick = '0;
    if (found) pick[best_i] = 1'b1;
  end
endmodule

// File: rtl/intr_route_engine.sv
module intr_route_engine
  import intr_route_pkg::*;
#(
  parameter int NCPU  = 8,
  parameter int PRIW  = 8,
  parameter int PIN_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [7:0]             req_dest,
  input  logic                   req_logical,
  input  logic [2:0]             req_dmode,
  input  logic [7:0]             req_vector,
  input  logic                   req_level,
  input  logic [PIN_W-1:0]       req_pin,
  input  logic [NCPU-1:0]        cpu_present,
  input  logic [NCPU*8-1:0]      cpu_phys_id,
  input  logic [NCPU*8-1:0]      cpu_log_id,
  input  logic [NCPU*PRIW-1:0]   cpu_prio,
  output logic                   busy,
  output logic [NCPU-1:0]        inj_pulse,
  output logic [7:0]             inj_vector,
  output logic                   inj_level,
  output logic [NCPU-1:0]        nmi_pulse,
  output logic                   done,
  output logic                   accepted
);
  localparam logic [NCPU-1:0] CPU0_ONLY = NCPU'(1);

  route_state_e     state_q;
  route_req_t       req_q;
  logic [PIN_W-1:0] pin_q;
  logic [NCPU-1:0]  pend_q;
  logic             nmi_q;
  logic             ok_q;

  logic [NCPU-1:0]  resolved;
  logic [NCPU-1:0]  lowest;
  logic [NCPU-1:0]  next_bit;
  logic [NCPU-1:0]  final_mask;
  logic             mode_ok;
  logic             pin_zero;

  intr_dest_match #(.NCPU(NCPU)) u_match (
    .dest        (req_q.dest),
    .logical     (req_q.logical),
    .present     (cpu_present),
    .phys_ids    (cpu_phys_id),
    .log_ids     (cpu_log_id),
    .target_mask (resolved)
  );

  intr_lowest_pick #(.NCPU(NCPU), .PRIW(PRIW)) u_pick (
    .cand (resolved),
    .prio (cpu_prio),
    .pick (lowest)
  );

  lsb_isolate #(.W(NCPU)) u_next (
    .in_vec     (pend_q),
    .out_onehot (next_bit)
  );

  assign pin_zero = (pin_q == '0);

  always_comb begin
    mode_ok    = 1'b1;
    final_mask = '0;
    case (req_q.dmode)
      DM_FIXED:  final_mask = pin_zero ? CPU0_ONLY : resolved;
      DM_LOWEST: final_mask = pin_zero ? CPU0_ONLY : lowest;
      DM_NMI:    final_mask = resolved;
      default:   mode_ok    = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_q     <= '0;
      pin_q     <= '0;
      pend_q    <= '0;
      nmi_q     <= 1'b0;
      ok_q      <= 1'b0;
      inj_pulse <= '0;
      nmi_pulse <= '0;
      done      <= 1'b0;
      accepted  <= 1'b0;
    end else begin
      inj_pulse <= '0;
      nmi_pulse <= '0;
      done      <= 1'b0;
      accepted  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            req_q.dest    <= req_dest;
            req_q.logical <= req_logical;
            req_q.dmode   <= req_dmode;
            req_q.vector  <= req_vector;
            req_q.level   <= req_level;
            pin_q         <= req_pin;
            state_q       <= ST_RESOLVE;
          end
        end
        ST_RESOLVE: begin
          nmi_q <= (req_q.dmode == DM_NMI);
          // The empty check uses the resolved set, before any pin override.
          if (!mode_ok || (resolved == '0)) begin
            ok_q    <= 1'b0;
            state_q <= ST_FINISH;
          end else begin
            ok_q    <= 1'b1;
            pend_q  <= final_mask;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (nmi_q) nmi_pulse <= next_bit;
          else       inj_pulse <= next_bit;
          pend_q <= pend_q & ~next_bit;
          if ((pend_q & ~next_bit) == '0) state_q <= ST_FINISH;
        end
        ST_FINISH: begin
          done     <= 1'b1;
          accepted <= ok_q;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign inj_vector = req_q.vector;
  assign inj_level  = req_q.level;
endmodule

// File: rtl/intr_route_engine_chk.sv
module intr_route_engine_chk #(
  parameter int NCPU = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            accepted,
  input logic [NCPU-1:0] inj_pulse,
  input logic [NCPU-1:0] nmi_pulse
);
  AST_INJ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inj_pulse)); // R6

  AST_NMI_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nmi_pulse)); // R9

  AST_NO_MIXED_KIND: assert property (@(posedge clk) disable iff (rst)
    !((|inj_pulse) && (|nmi_pulse))); // R9

  AST_INJ_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    ((|inj_pulse) && $past(|inj_pulse)) |-> (inj_pulse > $past(inj_pulse))); // R6

  AST_NMI_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    ((|nmi_pulse) && $past(|nmi_pulse)) |-> (nmi_pulse > $past(nmi_pulse))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_ACCEPT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    accepted |-> done); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R11

  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((inj_pulse == '0) && (nmi_pulse == '0))); // R11

  AST_ACCEPT_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
    accepted |-> $past((|inj_pulse) || (|nmi_pulse))); // R6
endmodule

bind intr_route_engine intr_route_engine_chk #(.NCPU(NCPU)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .accepted  (accepted),
  .inj_pulse (inj_pulse),
  .nmi_pulse (nmi_pulse)
);

// File: tb/intr_route_engine_tb.sv
module intr_route_engine_tb;
  localparam int NCPU  = 8;
  localparam int PRIW  = 4;
  localparam int PIN_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [2:0] req_dmode = '0;
  logic [7:0] req_vector = '0;
  logic req_level = 1'b0;
  logic [PIN_W-1:0] req_pin = '0;
  logic [NCPU-1:0] cpu_present;
  logic [NCPU*8-1:0] cpu_phys_id;
  logic [NCPU*8-1:0] cpu_log_id;
  logic [NCPU*PRIW-1:0] cpu_prio;
  logic busy, inj_level, done, accepted;
  logic [NCPU-1:0] inj_pulse, nmi_pulse;
  logic [7:0] inj_vector;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  intr_route_engine #(.NCPU(NCPU), .PRIW(PRIW), .PIN_W(PIN_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_dmode(req_dmode), .req_vector(req_vector),
    .req_level(req_level), .req_pin(req_pin), .cpu_present(cpu_present),
    .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id), .cpu_prio(cpu_prio),
    .busy(busy), .inj_pulse(inj_pulse), .inj_vector(inj_vector),
    .inj_level(inj_level), .nmi_pulse(nmi_pulse), .done(done),
    .accepted(accepted)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present: CPUs 0,2,3,4,5,7. CPUs 1,3,5 share physical ID 0x21.
  // CPU7 logical 0x90 shares bit 4 with CPU4. Absent CPUs hold priority 0.
  task automatic setup_cpus();
    cpu_present = 8'b1011_1101;
    for (int i = 0; i < NCPU; i++) begin
      cpu_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
      cpu_log_id[i*8 +: 8]  = 8'(1 << i);
    end
    cpu_phys_id[1*8 +: 8] = 8'h21;
    cpu_phys_id[3*8 +: 8] = 8'h21;
    cpu_phys_id[5*8 +: 8] = 8'h21;
    cpu_log_id[7*8 +: 8]  = 8'h90;
    cpu_prio = {4'd3, 4'd0, 4'd2, 4'd9, 4'd2, 4'd7, 4'd0, 4'd5};
  endtask

  task automatic run_req(input string tag, input logic [7:0] dest, input logic lg,
                         input logic [2:0] dm, input logic [7:0] vec, input logic lvl,
                         input logic [PIN_W-1:0] pin, input logic [7:0] exp_mask,
                         input logic exp_nmi, input logic exp_acc, input bit poke_busy);
    logic [7:0] remaining, got_mask, exp_bit, pulses, other;
    int last_pulse, done_cyc;
    bit order_bad, side_bad;
    logic acc_seen;
    remaining = exp_mask; got_mask = '0; last_pulse = -1; done_cyc = -1;
    order_bad = 0; side_bad = 0; acc_seen = 0;
    @(negedge clk);
    req_dest = dest; req_logical = lg; req_dmode = dm; req_vector = vec;
    req_level = lvl; req_pin = pin; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", busy === 1'b1, {tag, " busy after request"}, 32'(busy), 32'd1);
    for (int c = 0; c < 40 && done_cyc < 0; c++) begin
      if (poke_busy && c == 1) begin
        req_valid = 1'b1; req_dmode = 3'b100; req_vector = 8'hEE; req_pin = '0;
      end
      if (poke_busy && c == 2) req_valid = 1'b0;
      @(negedge clk);
      pulses = exp_nmi ? nmi_pulse : inj_pulse;
      other  = exp_nmi ? inj_pulse : nmi_pulse;
      if (other != '0) side_bad = 1;
      if (pulses != '0) begin
        exp_bit = remaining & (~remaining + 8'd1);
        if (pulses !== exp_bit) order_bad = 1;
        if (last_pulse >= 0 && last_pulse != c - 1) order_bad = 1;
        if (!exp_nmi && (inj_vector !== vec || inj_level !== lvl)) order_bad = 1;
        remaining = remaining & ~pulses;
        got_mask  = got_mask | pulses;
        last_pulse = c;
      end
      if (done) begin
        done_cyc = c;
        acc_seen = accepted;
      end
    end
    check(tag, (got_mask == exp_mask) && !order_bad && !side_bad,
          "targets, order, channel and payload", 32'(got_mask), 32'(exp_mask));
    check(tag, (done_cyc >= 0) && (acc_seen === exp_acc), "accepted with done",
          32'(acc_seen), 32'(exp_acc));
    if (exp_mask != '0)
      check("R6", done_cyc == last_pulse + 1, {tag, " done one cycle after last pulse"},
            32'(done_cyc), 32'(last_pulse + 1));
    else
      check("R5", (done_cyc >= 0) && (last_pulse < 0), {tag, " done without pulses"},
            32'(last_pulse), 32'hFFFF_FFFF);
    if (poke_busy) begin
      bit stray = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (done || busy || inj_pulse != '0 || nmi_pulse != '0) stray = 1;
      end
      check("R11", !stray, "request during busy was ignored", 32'(stray), 32'd0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {busy, done, accepted} === 3'b000 && inj_pulse === '0 && nmi_pulse === '0,
          "outputs in reset", {busy, done, accepted, inj_pulse, nmi_pulse}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", busy === 1'b0 && done === 1'b0, "idle after reset",
          {busy, done}, 32'd0);
  endtask

  task automatic t_physical();
    run_req("R2", 8'hFF, 1'b0, 3'b000, 8'h41, 1'b0, 5'd3, 8'hBD, 1'b0, 1'b1, 0);
    run_req("R3", 8'h21, 1'b0, 3'b000, 8'h42, 1'b1, 5'd2, 8'h08, 1'b0, 1'b1, 0);
    run_req("R5", 8'h33, 1'b0, 3'b000, 8'h43, 1'b0, 5'd2, 8'h00, 1'b0, 1'b0, 0);
  endtask

  task automatic t_logical();
    run_req("R4", 8'h00, 1'b1, 3'b000, 8'h50, 1'b0, 5'd4, 8'h00, 1'b0, 1'b0, 0);
    run_req("R4", 8'h12, 1'b1, 3'b000, 8'h55, 1'b1, 5'd4, 8'h90, 1'b0, 1'b1, 0);
  endtask

  task automatic t_lowest();
    run_req("R7", 8'hFF, 1'b0, 3'b001, 8'h60, 1'b1, 5'd6, 8'h08, 1'b0, 1'b1, 0);
    run_req("R7", 8'hA0, 1'b1, 3'b001, 8'h61, 1'b0, 5'd6, 8'h20, 1'b0, 1'b1, 0);
  endtask

  task automatic t_pin0();
    run_req("R8", 8'h12, 1'b1, 3'b000, 8'h70, 1'b0, 5'd0, 8'h01, 1'b0, 1'b1, 0);
    run_req("R8", 8'hFF, 1'b0, 3'b001, 8'h71, 1'b1, 5'd0, 8'h01, 1'b0, 1'b1, 0);
    run_req("R8", 8'h00, 1'b1, 3'b000, 8'h72, 1'b0, 5'd0, 8'h00, 1'b0, 1'b0, 0);
  endtask

  task automatic t_nmi();
    run_req("R9", 8'hFF, 1'b0, 3'b100, 8'h02, 1'b0, 5'd7, 8'hBD, 1'b1, 1'b1, 0);
    run_req("R9", 8'h12, 1'b1, 3'b100, 8'h02, 1'b0, 5'd0, 8'h90, 1'b1, 1'b1, 0);
  endtask

  task automatic t_unsupported();
    run_req("R10", 8'hFF, 1'b0, 3'b010, 8'h80, 1'b0, 5'd1, 8'h00, 1'b0, 1'b0, 0);
    run_req("R10", 8'hFF, 1'b0, 3'b111, 8'h81, 1'b0, 5'd1, 8'h00, 1'b0, 1'b0, 0);
  endtask

  task automatic t_busy();
    run_req("R11", 8'hFF, 1'b0, 3'b000, 8'h90, 1'b1, 5'd9, 8'hBD, 1'b0, 1'b1, 1);
  endtask

  initial begin
    setup_cpus();
    t_reset();
    t_physical();
    t_logical();
    t_lowest();
    t_pin0();
    t_nmi();
    t_unsupported();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule